// File: doc/BRIEF.md
# Flash Program/Erase Suspend-Resume Controller

This block keeps the suspend bookkeeping of a serial flash model's internal write engine. Each command is presented once, when chip select is released, as a decoded opcode, the number of bits clocked during the select window, and the target address. The block then decides whether the command is accepted, aborted or ignored, and keeps the status bits current: busy, write-enable latch, program-suspended, erase-suspended and the combined suspend flag.

A running program or erase can be frozen by a suspend command and restarted later by a resume command. An erase may be suspended, a program started in another block, and that program suspended too. Resume always restarts the program first. The real program and erase timing is replaced by a busy-duration counter, and the remaining count is kept across a suspend. A read-address port reports whether a read falls in the suspended page or the suspended erase block, where array data would be undefined.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, busy, WEL, both suspend bits, the combined suspend bit, the command result and the read-undefined flag are all 0.
- R2: A command whose bit count is zero or not a multiple of eight has no effect and reports result ignored.
- R3: Suspend (opcode 0x75) taken while a program runs sets the program-suspended bit, and taken while an erase runs sets the erase-suspended bit. Either way busy drops on the next cycle. The combined bit is the OR of the two. Suspend while idle is ignored.
- R4: Resume (opcode 0x7A) is accepted only when the combined suspend bit is 1 and busy is 0, whatever WEL holds. Acceptance clears one suspend bit and raises busy. Otherwise it is ignored.
- R5: With both suspend bits set, the first resume restarts the program and leaves the erase suspended. A later resume, after the program finishes, restarts the erase.
- R6: A program (0x02) aimed at the erase-suspended 4 KB block, or an erase (0x20) aimed at the 4 KB block holding the program-suspended 256-byte page, is aborted and clears WEL.
- R7: Any other command not permitted while suspended, such as write-status (0x01), a second program while a program is suspended, or an erase outside the conflict case, is ignored and leaves WEL unchanged.
- R8: For RSM_GUARD cycles after a resume is accepted, a suspend of the resumed operation is ignored.
- R9: With rd_en high, rd_undef is 1 exactly when rd_addr lies in the suspended page or the suspended block, and 0 elsewhere.
- R10: A program keeps busy high for PROG_CYC cycles and an erase for ERASE_CYC cycles. A resumed operation stays busy only for the cycles it had left. Program and erase need WEL=1 (set by 0x06, cleared by 0x04) and clear it when they start.
- R11: cmd_res is valid in the cycle after the command. It reads 0 for no command, 1 for accepted, 2 for aborted and 3 for ignored.
- R12: A command is judged on the state before the clock edge. A suspend that lands in the final busy cycle is therefore taken, and it saves one remaining cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle chip-select release event |
| cmd_op | input | 8 | Opcode byte of the finished command |
| cmd_bits | input | BITS_W | Bits clocked during the select window |
| cmd_addr | input | ADDR_W | Target address of program or erase |
| rd_en | input | 1 | Read address valid |
| rd_addr | input | ADDR_W | Current array read address |
| st_busy | output | 1 | Busy (program or erase running) |
| st_wel | output | 1 | Write-enable latch |
| st_psus | output | 1 | Program suspended |
| st_esus | output | 1 | Erase suspended |
| st_sus | output | 1 | Either operation suspended |
| cmd_res | output | 2 | Result of the previous cycle's command |
| rd_undef | output | 1 | Read lands in a suspended region |

## Verification
The delicate overlap is a suspend arriving in the very cycle that the busy counter expires, so the command decision and the operation completion fall on the same clock edge. The bench times a suspend to land exactly on the last busy cycle of a fresh program. It expects the suspend to win, with one cycle saved, and it expects a resume to give exactly one more busy cycle. A second overlap, a resume racing the guard window against a fresh suspend, is provoked by back-to-back commands. Both cases are judged against the bench's reference model on every clock.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_PROG  = 2'd1,
        RUN_ERASE = 2'd2
    } run_e;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_ACCEPT = 2'd1,
        RES_ABORT  = 2'd2,
        RES_IGNORE = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        CMD_OTHER,
        CMD_WREN,
        CMD_WRDI,
        CMD_PROG,
        CMD_ERASE,
        CMD_WRSR,
        CMD_SUSP,
        CMD_RSM
    } cmd_e;

endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
    import fsr_pkg::*;
#(
    parameter int          BITS_W   = 6,
    parameter logic [7:0]  OP_SUSP  = 8'h75,
    parameter logic [7:0]  OP_RSM   = 8'h7A,
    parameter logic [7:0]  OP_WREN  = 8'h06,
    parameter logic [7:0]  OP_WRDI  = 8'h04,
    parameter logic [7:0]  OP_PROG  = 8'h02,
    parameter logic [7:0]  OP_ERASE = 8'h20,
    parameter logic [7:0]  OP_WRSR  = 8'h01
) (
    input  logic [7:0]        op,
    input  logic [BITS_W-1:0] bits,
    output cmd_e              kind,
    output logic              frame_ok
);

    // A full opcode byte and release on a byte boundary
    always_comb begin
        frame_ok = (bits != '0) && (bits[2:0] == 3'b000);
    end

    always_comb begin
        kind = CMD_OTHER;
        if      (op == OP_SUSP)  kind = CMD_SUSP;
        else if (op == OP_RSM)   kind = CMD_RSM;
        else if (op == OP_WREN)  kind = CMD_WREN;
        else if (op == OP_WRDI)  kind = CMD_WRDI;
        else if (op == OP_PROG)  kind = CMD_PROG;
        else if (op == OP_ERASE) kind = CMD_ERASE;
        else if (op == OP_WRSR)  kind = CMD_WRSR;
    end

endmodule

// File: rtl/fsr_window.sv
module fsr_window #(
    parameter int ADDR_W = 24,
    parameter int WIN    = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base_src,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(WIN - 1);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WIN);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;

    // Region base is the aligned start of the window holding base_src
    always_comb begin
        base = base_src & ~MASK;
        off  = addr - base;
        hit  = (addr >= base) && (off < SPAN);
    end

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
    import fsr_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          BITS_W     = 6,
    parameter int          PAGE_BYTES = 256,
    parameter int          BLK_BYTES  = 4096,
    parameter int          PROG_CYC   = 20,
    parameter int          ERASE_CYC  = 40,
    parameter int          RSM_GUARD  = 4,
    parameter logic [7:0]  OP_SUSP    = 8'h75,
    parameter logic [7:0]  OP_RSM     = 8'h7A,
    parameter logic [7:0]  OP_WREN    = 8'h06,
    parameter logic [7:0]  OP_WRDI    = 8'h04,
    parameter logic [7:0]  OP_PROG    = 8'h02,
    parameter logic [7:0]  OP_ERASE   = 8'h20,
    parameter logic [7:0]  OP_WRSR    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [BITS_W-1:0] cmd_bits,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              st_busy,
    output logic              st_wel,
    output logic              st_psus,
    output logic              st_esus,
    output logic              st_sus,
    output logic [1:0]        cmd_res,
    output logic              rd_undef
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int GRD_W   = (RSM_GUARD > 0) ? $clog2(RSM_GUARD + 1) : 1;
    localparam int NLOOK   = 4;
    // lookup slots: 0 read/page of program suspend, 1 read/erase block,
    //               2 command/erase block, 3 command/block of program page
    localparam int LK_RD_PPAGE = 0;
    localparam int LK_RD_EBLK  = 1;
    localparam int LK_CM_EBLK  = 2;
    localparam int LK_CM_PBLK  = 3;

    typedef struct packed {
        run_e              run;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] cur;
        logic              ps;
        logic              es;
        logic [CNT_W-1:0]  prem;
        logic [CNT_W-1:0]  erem;
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] ea;
        logic              wel;
        logic [GRD_W-1:0]  grd;
        res_e              res;
    } st_t;

    st_t  st_d, st_q;
    cmd_e kind;
    logic frame_ok;
    logic halt;
    logic [NLOOK-1:0] lk_hit;

    fsr_cmd_decode #(
        .BITS_W   (BITS_W),
        .OP_SUSP  (OP_SUSP),
        .OP_RSM   (OP_RSM),
        .OP_WREN  (OP_WREN),
        .OP_WRDI  (OP_WRDI),
        .OP_PROG  (OP_PROG),
        .OP_ERASE (OP_ERASE),
        .OP_WRSR  (OP_WRSR)
    ) u_dec (
        .op       (cmd_op),
        .bits     (cmd_bits),
        .kind     (kind),
        .frame_ok (frame_ok)
    );

    for (genvar gi = 0; gi < NLOOK; gi++) begin : g_look
        localparam int WIN = (gi == LK_RD_PPAGE) ? PAGE_BYTES : BLK_BYTES;
        logic [ADDR_W-1:0] a_sel;
        logic [ADDR_W-1:0] r_sel;
        always_comb begin
            a_sel = (gi < 2) ? rd_addr : cmd_addr;
            r_sel = (gi == LK_RD_EBLK || gi == LK_CM_EBLK) ? st_q.ea : st_q.pa;
        end
        fsr_window #(
            .ADDR_W (ADDR_W),
            .WIN    (WIN)
        ) u_win (
            .addr     (a_sel),
            .base_src (r_sel),
            .hit      (lk_hit[gi])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.res = RES_NONE;
        halt     = 1'b0;
        if (st_q.grd != '0) begin
            st_d.grd = st_q.grd - 1'b1;
        end

        if (cmd_valid) begin
            st_d.res = RES_IGNORE;
            if (frame_ok) begin
                case (kind)
                    CMD_SUSP: begin
                        if (st_q.run != RUN_IDLE && st_q.grd == '0) begin
                            halt     = 1'b1;
                            st_d.run = RUN_IDLE;
                            st_d.cnt = '0;
                            st_d.res = RES_ACCEPT;
                            if (st_q.run == RUN_PROG) begin
                                st_d.ps   = 1'b1;
                                st_d.prem = st_q.cnt;
                                st_d.pa   = st_q.cur;
                            end else begin
                                st_d.es   = 1'b1;
                                st_d.erem = st_q.cnt;
                                st_d.ea   = st_q.cur;
                            end
                        end
                    end
                    CMD_RSM: begin
                        if ((st_q.ps || st_q.es) && st_q.run == RUN_IDLE) begin
                            st_d.res = RES_ACCEPT;
                            st_d.grd = GRD_W'(RSM_GUARD);
                            if (st_q.ps) begin
                                st_d.ps  = 1'b0;
                                st_d.run = RUN_PROG;
                                st_d.cnt = st_q.prem;
                                st_d.cur = st_q.pa;
                            end else begin
                                st_d.es  = 1'b0;
                                st_d.run = RUN_ERASE;
                                st_d.cnt = st_q.erem;
                                st_d.cur = st_q.ea;
                            end
                        end
                    end
                    CMD_WREN: begin
                        if (st_q.run == RUN_IDLE) begin
                            st_d.wel = 1'b1;
                            st_d.res = RES_ACCEPT;
                        end
                    end
                    CMD_WRDI: begin
                        if (st_q.run == RUN_IDLE) begin
                            st_d.wel = 1'b0;
                            st_d.res = RES_ACCEPT;
                        end
                    end
                    CMD_PROG: begin
                        if (st_q.run != RUN_IDLE) begin
                            st_d.res = RES_IGNORE;
                        end else if (st_q.es && lk_hit[LK_CM_EBLK]) begin
                            st_d.wel = 1'b0;
                            st_d.res = RES_ABORT;
                        end else if (st_q.ps || !st_q.wel) begin
                            st_d.res = RES_IGNORE;
                        end else begin
                            st_d.run = RUN_PROG;
                            st_d.cnt = CNT_W'(PROG_CYC);
                            st_d.cur = cmd_addr;
                            st_d.wel = 1'b0;
                            st_d.res = RES_ACCEPT;
                        end
                    end
                    CMD_ERASE: begin
                        if (st_q.run != RUN_IDLE) begin
                            st_d.res = RES_IGNORE;
                        end else if (st_q.ps && lk_hit[LK_CM_PBLK]) begin
                            st_d.wel = 1'b0;
                            st_d.res = RES_ABORT;
                        end else if (st_q.ps || st_q.es || !st_q.wel) begin
                            st_d.res = RES_IGNORE;
                        end else begin
                            st_d.run = RUN_ERASE;
                            st_d.cnt = CNT_W'(ERASE_CYC);
                            st_d.cur = cmd_addr;
                            st_d.wel = 1'b0;
                            st_d.res = RES_ACCEPT;
                        end
                    end
                    CMD_WRSR: begin
                        if (st_q.run == RUN_IDLE && !st_q.ps && !st_q.es && st_q.wel) begin
                            st_d.wel = 1'b0;
                            st_d.res = RES_ACCEPT;
                        end
                    end
                    default: st_d.res = RES_IGNORE;
                endcase
            end
        end

        // engine step: a command sees the pre-edge state, suspend wins over completion
        if (st_q.run != RUN_IDLE && !halt) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.run = RUN_IDLE;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_busy  = (st_q.run != RUN_IDLE);
        st_wel   = st_q.wel;
        st_psus  = st_q.ps;
        st_esus  = st_q.es;
        st_sus   = st_q.ps | st_q.es;
        cmd_res  = st_q.res;
        rd_undef = rd_en && ((st_q.ps && lk_hit[LK_RD_PPAGE]) ||
                             (st_q.es && lk_hit[LK_RD_EBLK]));
    end

    AST_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !frame_ok) |=> ($stable(st_psus) && $stable(st_esus) && $stable(st_wel))); // R2

    AST_SUSP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && frame_ok && kind == CMD_SUSP && st_busy && st_q.grd == '0)
        |=> (!st_busy && st_sus)); // R3

    AST_RSM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && frame_ok && kind == CMD_RSM && st_sus && !st_busy) |=> st_busy); // R4

    AST_NEST_PFIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && frame_ok && kind == CMD_RSM && st_psus && st_esus && !st_busy)
        |=> (!st_psus && st_esus)); // R5

    AST_ABORT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_res == RES_ABORT) |-> !st_wel); // R6

    AST_WRSR_SUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind == CMD_WRSR && st_sus) |=> ($stable(st_wel) && cmd_res == RES_IGNORE)); // R7

    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && frame_ok && kind == CMD_SUSP && st_busy && st_q.grd != '0 && st_q.cnt > CNT_W'(1))
        |=> (st_busy && !$rose(st_sus))); // R8

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_sus) |-> !rd_undef); // R9

endmodule

// File: tb/flash_susp_ctrl_tb.sv
module flash_susp_ctrl_tb_top;

    localparam int CLK_P     = 10;
    localparam int PROG_CYC  = 20;
    localparam int ERASE_CYC = 40;
    localparam int GUARD     = 4;
    localparam int PG_SH     = 8;
    localparam int BK_SH     = 12;
    localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_PROG = 8'h02, C_ERASE = 8'h20,
                           C_WRSR = 8'h01, C_SUSP = 8'h75, C_RSM = 8'h7A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [5:0]  cmd_bits = '0;
    logic [23:0] cmd_addr = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        st_busy, st_wel, st_psus, st_esus, st_sus, rd_undef;
    logic [1:0]  cmd_res;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_P / 2) clk = ~clk;

    flash_susp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .st_busy(st_busy), .st_wel(st_wel), .st_psus(st_psus), .st_esus(st_esus),
        .st_sus(st_sus), .cmd_res(cmd_res), .rd_undef(rd_undef)
    );

    // behavioural reference: run 0 idle, 1 program, 2 erase
    int m_run, m_cnt, m_ca, m_ps, m_es, m_pr, m_er, m_pa, m_ea, m_wel, m_grd, m_res;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_ca = 0; m_ps = 0; m_es = 0; m_pr = 0; m_er = 0;
            m_pa = 0; m_ea = 0; m_wel = 0; m_grd = 0; m_res = 0;
        end else begin
            int n_run, n_cnt, n_ca, n_ps, n_es, n_pr, n_er, n_pa, n_ea, n_wel, n_grd, n_res;
            int a;
            bit frz;
            n_run = m_run; n_cnt = m_cnt; n_ca = m_ca; n_ps = m_ps; n_es = m_es;
            n_pr = m_pr; n_er = m_er; n_pa = m_pa; n_ea = m_ea; n_wel = m_wel;
            n_grd = (m_grd > 0) ? m_grd - 1 : 0;
            n_res = 0;
            frz = 0;
            a = int'(cmd_addr);
            if (cmd_valid) begin
                n_res = 3;
                if (cmd_bits != 0 && (cmd_bits % 8) == 0) begin
                    if (cmd_op == C_SUSP) begin
                        if (m_run != 0 && m_grd == 0) begin
                            frz = 1; n_run = 0; n_cnt = 0; n_res = 1;
                            if (m_run == 1) begin n_ps = 1; n_pr = m_cnt; n_pa = m_ca; end
                            else begin n_es = 1; n_er = m_cnt; n_ea = m_ca; end
                        end
                    end else if (cmd_op == C_RSM) begin
                        if ((m_ps || m_es) && m_run == 0) begin
                            n_res = 1; n_grd = GUARD;
                            if (m_ps) begin n_ps = 0; n_run = 1; n_cnt = m_pr; n_ca = m_pa; end
                            else begin n_es = 0; n_run = 2; n_cnt = m_er; n_ca = m_ea; end
                        end
                    end else if (cmd_op == C_WREN || cmd_op == C_WRDI) begin
                        if (m_run == 0) begin n_wel = (cmd_op == C_WREN); n_res = 1; end
                    end else if (cmd_op == C_PROG) begin
                        if (m_run != 0) n_res = 3;
                        else if (m_es && (a >> BK_SH) == (m_ea >> BK_SH)) begin n_wel = 0; n_res = 2; end
                        else if (m_ps || !m_wel) n_res = 3;
                        else begin n_run = 1; n_cnt = PROG_CYC; n_ca = a; n_wel = 0; n_res = 1; end
                    end else if (cmd_op == C_ERASE) begin
                        if (m_run != 0) n_res = 3;
                        else if (m_ps && (a >> BK_SH) == (m_pa >> BK_SH)) begin n_wel = 0; n_res = 2; end
                        else if (m_ps || m_es || !m_wel) n_res = 3;
                        else begin n_run = 2; n_cnt = ERASE_CYC; n_ca = a; n_wel = 0; n_res = 1; end
                    end else if (cmd_op == C_WRSR) begin
                        if (m_run == 0 && !m_ps && !m_es && m_wel) begin n_wel = 0; n_res = 1; end
                    end
                end
            end
            if (m_run != 0 && !frz) begin
                if (m_cnt <= 1) begin n_run = 0; n_cnt = 0; end
                else n_cnt = m_cnt - 1;
            end
            m_run = n_run; m_cnt = n_cnt; m_ca = n_ca; m_ps = n_ps; m_es = n_es; m_pr = n_pr;
            m_er = n_er; m_pa = n_pa; m_ea = n_ea; m_wel = n_wel; m_grd = n_grd; m_res = n_res;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ex_und;
            ex_und = (rd_en && ((m_ps && (int'(rd_addr) >> PG_SH) == (m_pa >> PG_SH)) ||
                                (m_es && (int'(rd_addr) >> BK_SH) == (m_ea >> BK_SH)))) ? 1 : 0;
            chk("R3 R9 R10 R11 model",
                int'({st_busy, st_wel, st_psus, st_esus, st_sus, cmd_res, rd_undef}),
                int'({(m_run != 0), (m_wel != 0), (m_ps != 0), (m_es != 0),
                      (m_ps != 0 || m_es != 0), 2'(m_res), (ex_und != 0)}));
        end
    end

    task automatic send(input logic [7:0] op, input int bits, input int addr);
        cmd_valid = 1'b1; cmd_op = op; cmd_bits = 6'(bits); cmd_addr = 24'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (st_busy) @(negedge clk);
    endtask

    task automatic rd_probe(input int addr, input int exp, input string tag);
        rd_en = 1'b1; rd_addr = 24'(addr);
        @(negedge clk);
        chk(tag, int'(rd_undef), exp);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'({st_busy, st_wel, st_psus, st_esus, st_sus, cmd_res, rd_undef}), 0);

        // R10 program without WEL ignored, then fresh program duration
        send(C_PROG, 32, 'h000100);
        chk("R10 prog needs WEL", int'(cmd_res), 3);
        send(C_WREN, 8, 0);
        chk("R11 accept code", int'(cmd_res), 1);
        send(C_PROG, 32, 'h000100);
        chk("R10 WEL cleared at start", int'(st_wel), 0);
        begin
            int n = 0;
            while (st_busy) begin n++; @(negedge clk); end
            chk("R10 program busy cycles", n, PROG_CYC);
        end

        // R2 / R3 suspend framing and program suspend
        send(C_WREN, 8, 0);
        send(C_PROG, 32, 'h001234);
        idle(4);
        send(C_SUSP, 7, 0);
        chk("R2 short frame", int'({st_busy, st_psus, cmd_res}), 'b1_0_11);
        send(C_SUSP, 12, 0);
        chk("R2 unaligned frame", int'({st_busy, st_psus, cmd_res}), 'b1_0_11);
        send(C_SUSP, 16, 0);
        chk("R3 program suspend", int'({st_busy, st_psus, st_esus, st_sus, cmd_res}), 'b0_1_0_1_01);
        send(C_SUSP, 8, 0);
        chk("R3 suspend idle ignored", int'(cmd_res), 3);
        rd_probe('h0012FF, 1, "R9 in page");
        rd_probe('h001300, 0, "R9 past page");
        rd_probe('h0011FF, 0, "R9 before page");

        // R4 resume with WEL=0, R8 guard
        send(C_RSM, 8, 0);
        chk("R4 resume", int'({st_busy, st_psus, st_sus, st_wel, cmd_res}), 'b1_0_0_0_01);
        send(C_SUSP, 8, 0);
        chk("R8 guard ignores suspend", int'({st_busy, st_psus, cmd_res}), 'b1_0_11);
        send(C_RSM, 8, 0);
        chk("R4 resume while busy", int'(cmd_res), 3);
        wait_idle();

        // erase suspend, conflicts and nesting
        send(C_WREN, 8, 0);
        send(C_ERASE, 32, 'h005000);
        idle(3);
        send(C_SUSP, 8, 0);
        chk("R3 erase suspend", int'({st_busy, st_psus, st_esus, st_sus}), 'b0_0_1_1);
        send(C_WREN, 8, 0);
        send(C_WRSR, 16, 0);
        chk("R7 wrsr ignored", int'({st_wel, cmd_res}), 'b1_11);
        send(C_PROG, 32, 'h005100);
        chk("R6 prog abort", int'({st_wel, cmd_res, st_busy}), 'b0_10_0);
        send(C_WREN, 8, 0);
        send(C_PROG, 32, 'h007010);
        chk("R3 prog during erase susp", int'({st_busy, cmd_res}), 'b1_01);
        idle(3);
        send(C_SUSP, 8, 0);
        chk("R5 nested suspend", int'({st_psus, st_esus, st_busy}), 'b1_1_0);
        send(C_WREN, 8, 0);
        send(C_ERASE, 32, 'h007800);
        chk("R6 erase abort", int'({st_wel, cmd_res}), 'b0_10);
        send(C_WREN, 8, 0);
        send(C_ERASE, 32, 'h009000);
        chk("R7 erase ignored", int'({st_wel, cmd_res}), 'b1_11);
        send(C_PROG, 32, 'h00A000);
        chk("R7 second prog ignored", int'({st_wel, cmd_res, st_busy}), 'b1_11_0);
        rd_probe('h0070AA, 1, "R9 nested page");
        rd_probe('h005FFF, 1, "R9 erase block");
        rd_probe('h007100, 0, "R9 outside");
        send(C_RSM, 8, 0);
        chk("R5 program first", int'({st_psus, st_esus, st_busy}), 'b0_1_1);
        wait_idle();
        chk("R5 erase still held", int'(st_esus), 1);
        send(C_RSM, 8, 0);
        chk("R5 erase resumed", int'({st_esus, st_busy, cmd_res}), 'b0_1_01);
        wait_idle();
        send(C_WRDI, 8, 0);
        chk("R10 wrdi", int'(st_wel), 0);

        // R12 suspend in the final busy cycle
        send(C_WREN, 8, 0);
        send(C_PROG, 32, 'h000000);
        idle(PROG_CYC - 1);
        send(C_SUSP, 8, 0);
        chk("R12 late suspend taken", int'({st_psus, st_busy, cmd_res}), 'b1_0_01);
        send(C_RSM, 8, 0);
        chk("R12 resumed busy", int'(st_busy), 1);
        @(negedge clk);
        chk("R12 one cycle left", int'({st_busy, st_sus}), 0);

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule